// File: doc/BRIEF.md
# Clock-Reset Status Flag Register

This block is the 8-bit status and interrupt flag register of a clock, reset and power management unit. It keeps sticky flags that record why the chip last reset (power-on, low supply voltage, illegal address) and a flag for the end of each periodic timer period. It also mirrors two live status signals: PLL lock and oscillator qualified. Each live signal has a sticky change-detect flag that sets on every edge of that signal. Software clears event flags by writing ones to them over a simple register write port. A 3-bit enable register picks which of the timeout, lock-change and oscillator-change flags drive the registered interrupt request.

The block also picks the PLL output divide ratio. While the registered lock status is low, the ratio is forced to a safe divide-by-4. Once lock is seen, the ratio becomes the programmed post-divider value plus one. The analog PLL, the oscillator, reset generation and the timer counter all live outside the block. They reach it as level or pulse inputs.

Top module: `clkrst_flag_reg`

## Requirements
- R1: When `porRstN` is low, the flags go to 8'h40 at once: only bit 6 (power-on) is set. The enables and `irqOut` go to 0, and `pllDivRatio` reads 4.
- R2: A `timerTick` pulse sampled at a clock edge sets flag bit 7 after that edge.
- R3: A write with `wrFlagEn` clears every event bit (7, 6, 5, 4, 2, 1) whose `wrData` bit is 1. Event bits written with 0 keep their value.
- R4: A `lowVoltEvt` pulse sets bit 5 and an `illegalAddrEvt` pulse sets bit 2. Both bits stay set until they are cleared by a write.
- R5: Bit 3 shows `pllLockIn` as sampled at the previous edge. Bit 4 sets whenever bit 3 changes, in either direction.
- R6: Bit 0 shows `oscGoodIn` as sampled at the previous edge, forced to 0 while `fullStopEnter` is high. Bit 1 sets whenever bit 0 changes, in either direction.
- R7: Writes have no effect on status bits 3 and 0.
- R8: If a hardware set event and a write-one clear hit the same bit in the same cycle, the bit ends set.
- R9: `irqOut` one edge later is the OR of three terms: bit 7 AND enable bit 2, bit 4 AND enable bit 1, and bit 1 AND enable bit 0. The enable register is loaded from `wrData[2:0]` when `wrEnEn` is high.
- R10: `pllDivRatio` is 4 while bit 3 is 0, and `postDiv`+1 while bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| porRstN | input | 1 | Asynchronous active-low power-on reset |
| lowVoltEvt | input | 1 | Low-voltage reset cause pulse |
| illegalAddrEvt | input | 1 | Illegal-address reset cause pulse |
| timerTick | input | 1 | End of periodic timer period pulse |
| pllLockIn | input | 1 | Live PLL lock indication |
| oscGoodIn | input | 1 | Live oscillator qualified indication |
| fullStopEnter | input | 1 | Full stop mode entry; forces oscillator status low |
| wrFlagEn | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| wrEnEn | input | 1 | Write strobe for the interrupt enable register |
| wrData | input | 8 | Write data |
| postDiv | input | POSTDIV_W | Programmed post-divider value |
| flagsOut | output | 8 | Flag register read value |
| enablesOut | output | 3 | Enable register read value (bit2 timeout, bit1 lock, bit0 osc) |
| irqOut | output | 1 | Registered interrupt request |
| pllDivRatio | output | POSTDIV_W+1 | Selected PLL output divide ratio |

## Verification
Flag and status results appear after the same edge that samples their stimulus. The interrupt request appears one edge after the flag or enable that causes it. The divide ratio follows the registered lock bit with no further delay. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each check falls after exactly the number of rising edges it expects. Interrupt checks read once after the first edge, expecting the request still low, and again after the second edge. Same-cycle set and clear, and full stop entry with the oscillator still good, are driven as single-cycle patterns.

// File: rtl/clkrst_flag_pkg.sv
package clkrst_flag_pkg;
  localparam int FLAG_W  = 8;
  localparam int IRQ_SRC = 3;

  localparam int B_TMO  = 7;
  localparam int B_POR  = 6;
  localparam int B_LVR  = 5;
  localparam int B_LCHG = 4;
  localparam int B_LOCK = 3;
  localparam int B_ILA  = 2;
  localparam int B_OCHG = 1;
  localparam int B_OSC  = 0;

  localparam logic [FLAG_W-1:0] W1C_MASK  = 8'b1111_0110;
  localparam logic [FLAG_W-1:0] POR_FLAGS = 8'b0100_0000;

  // interrupt source i maps to flag bit IRQ_BIT[i]
  localparam int IRQ_BIT [IRQ_SRC] = '{B_OCHG, B_LCHG, B_TMO};

  typedef struct packed {
    logic [FLAG_W-1:0]  setMask;
    logic [FLAG_W-1:0]  clrMask;
    logic               lockNext;
    logic               oscNext;
    logic               enLoad;
    logic [IRQ_SRC-1:0] enVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/clkrst_flag_ctrl.sv
module clkrst_flag_ctrl
  import clkrst_flag_pkg::*;
(
  input  logic              lowVoltEvt,
  input  logic              illegalAddrEvt,
  input  logic              timerTick,
  input  logic              pllLockIn,
  input  logic              oscGoodIn,
  input  logic              fullStopEnter,
  input  logic              wrFlagEn,
  input  logic              wrEnEn,
  input  logic [FLAG_W-1:0] wrData,
  input  logic              lockCur,
  input  logic              oscCur,
  output ctrlStrobes_t      strobes
);
  logic lockNext;
  logic oscNext;

  assign lockNext = pllLockIn;
  assign oscNext  = oscGoodIn & ~fullStopEnter;

  always_comb begin
    strobes          = '0;
    strobes.lockNext = lockNext;
    strobes.oscNext  = oscNext;
    strobes.setMask[B_TMO]  = timerTick;
    strobes.setMask[B_LVR]  = lowVoltEvt;
    strobes.setMask[B_ILA]  = illegalAddrEvt;
    strobes.setMask[B_LCHG] = lockNext ^ lockCur;
    strobes.setMask[B_OCHG] = oscNext ^ oscCur;
    strobes.clrMask  = wrFlagEn ? (wrData & W1C_MASK) : '0;
    strobes.enLoad   = wrEnEn;
    strobes.enVal    = wrData[IRQ_SRC-1:0];
  end
endmodule

// File: rtl/clkrst_flag_dp.sv
module clkrst_flag_dp
  import clkrst_flag_pkg::*;
#(
  parameter int POSTDIV_W = 5
)(
  input  logic                 clk,
  input  logic                 porRstN,
  input  ctrlStrobes_t         strobes,
  input  logic [POSTDIV_W-1:0] postDiv,
  output logic [FLAG_W-1:0]    flagsOut,
  output logic [IRQ_SRC-1:0]   enablesOut,
  output logic                 irqOut,
  output logic [POSTDIV_W:0]   pllDivRatio
);
  localparam int DIV_W = POSTDIV_W + 1;
  localparam logic [DIV_W-1:0] SAFE_DIV = DIV_W'(4);

  logic [FLAG_W-1:0]  flagReg;
  logic [FLAG_W-1:0]  flagNext;
  logic [IRQ_SRC-1:0] enReg;
  logic [IRQ_SRC-1:0] srcVec;
  logic               irqReg;

  always_comb begin
    flagNext         = (flagReg & ~strobes.clrMask) | strobes.setMask;
    flagNext[B_LOCK] = strobes.lockNext;
    flagNext[B_OSC]  = strobes.oscNext;
  end

  for (genvar i = 0; i < IRQ_SRC; i++) begin : g_src
    assign srcVec[i] = flagReg[IRQ_BIT[i]] & enReg[i];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      flagReg <= POR_FLAGS;
      enReg   <= '0;
      irqReg  <= 1'b0;
    end else begin
      flagReg <= flagNext;
      if (strobes.enLoad) enReg <= strobes.enVal;
      irqReg  <= |srcVec;
    end
  end

  assign pllDivRatio = flagReg[B_LOCK] ? ({1'b0, postDiv} + DIV_W'(1)) : SAFE_DIV;
  assign flagsOut    = flagReg;
  assign enablesOut  = enReg;
  assign irqOut      = irqReg;
endmodule

// File: rtl/clkrst_flag_reg.sv
module clkrst_flag_reg
  import clkrst_flag_pkg::*;
#(
  parameter int POSTDIV_W = 5
)(
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 lowVoltEvt,
  input  logic                 illegalAddrEvt,
  input  logic                 timerTick,
  input  logic                 pllLockIn,
  input  logic                 oscGoodIn,
  input  logic                 fullStopEnter,
  input  logic                 wrFlagEn,
  input  logic                 wrEnEn,
  input  logic [7:0]           wrData,
  input  logic [POSTDIV_W-1:0] postDiv,
  output logic [7:0]           flagsOut,
  output logic [2:0]           enablesOut,
  output logic                 irqOut,
  output logic [POSTDIV_W:0]   pllDivRatio
);
  ctrlStrobes_t strobes;

  clkrst_flag_ctrl ctrl_i (
    .lowVoltEvt(lowVoltEvt), .illegalAddrEvt(illegalAddrEvt),
    .timerTick(timerTick), .pllLockIn(pllLockIn), .oscGoodIn(oscGoodIn),
    .fullStopEnter(fullStopEnter), .wrFlagEn(wrFlagEn), .wrEnEn(wrEnEn),
    .wrData(wrData), .lockCur(flagsOut[B_LOCK]), .oscCur(flagsOut[B_OSC]),
    .strobes(strobes)
  );

  clkrst_flag_dp #(.POSTDIV_W(POSTDIV_W)) dp_i (
    .clk(clk), .porRstN(porRstN), .strobes(strobes), .postDiv(postDiv),
    .flagsOut(flagsOut), .enablesOut(enablesOut), .irqOut(irqOut),
    .pllDivRatio(pllDivRatio)
  );
endmodule

// File: rtl/clkrst_flag_chk.sv
module clkrst_flag_chk #(
  parameter int POSTDIV_W = 5
)(
  input logic                 clk,
  input logic                 porRstN,
  input logic                 lowVoltEvt,
  input logic                 illegalAddrEvt,
  input logic                 timerTick,
  input logic                 pllLockIn,
  input logic                 fullStopEnter,
  input logic                 wrFlagEn,
  input logic [7:0]           wrData,
  input logic [POSTDIV_W-1:0] postDiv,
  input logic [7:0]           flagsOut,
  input logic [2:0]           enablesOut,
  input logic                 irqOut,
  input logic [POSTDIV_W:0]   pllDivRatio
);
  // R2
  timeout_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    timerTick |=> flagsOut[7]);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (wrFlagEn && wrData[5] && !lowVoltEvt) |=> !flagsOut[5]);
  // R4
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (flagsOut[2] && !(wrFlagEn && wrData[2])) |=> flagsOut[2]);
  // R5
  lock_follow_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (pllLockIn != flagsOut[3]) |=> (flagsOut[4] && flagsOut[3] == $past(pllLockIn)));
  // R6
  fullstop_chk: assert property (@(posedge clk) disable iff (!porRstN)
    fullStopEnter |=> !flagsOut[0]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (illegalAddrEvt && wrFlagEn && wrData[2]) |=> flagsOut[2]);
  // R9
  irq_reg_chk: assert property (@(posedge clk) disable iff (!porRstN)
    1'b1 |=> irqOut == $past((flagsOut[7] & enablesOut[2]) |
                             (flagsOut[4] & enablesOut[1]) |
                             (flagsOut[1] & enablesOut[0])));
  // R10
  div_sel_chk: assert property (@(posedge clk) disable iff (!porRstN)
    pllDivRatio == (flagsOut[3] ? ({1'b0, postDiv} + 1'b1) : (POSTDIV_W+1)'(4)));
endmodule

bind clkrst_flag_reg clkrst_flag_chk #(.POSTDIV_W(POSTDIV_W)) chk_i (
  .clk(clk), .porRstN(porRstN), .lowVoltEvt(lowVoltEvt),
  .illegalAddrEvt(illegalAddrEvt), .timerTick(timerTick),
  .pllLockIn(pllLockIn), .fullStopEnter(fullStopEnter),
  .wrFlagEn(wrFlagEn), .wrData(wrData), .postDiv(postDiv),
  .flagsOut(flagsOut), .enablesOut(enablesOut), .irqOut(irqOut),
  .pllDivRatio(pllDivRatio)
);

// File: tb/clkrst_flag_reg_tb_top.sv
`timescale 1ns/1ps
module clkrst_flag_reg_tb_top;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic lowVoltEvt = 0, illegalAddrEvt = 0, timerTick = 0;
  logic pllLockIn = 0, oscGoodIn = 0, fullStopEnter = 0;
  logic wrFlagEn = 0, wrEnEn = 0;
  logic [7:0] wrData = '0;
  logic [PW-1:0] postDiv = 5'd9;
  logic [7:0] flagsOut;
  logic [2:0] enablesOut;
  logic irqOut;
  logic [PW:0] pllDivRatio;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clkrst_flag_reg #(.POSTDIV_W(PW)) dut_i (
    .clk(clk), .porRstN(porRstN), .lowVoltEvt(lowVoltEvt),
    .illegalAddrEvt(illegalAddrEvt), .timerTick(timerTick),
    .pllLockIn(pllLockIn), .oscGoodIn(oscGoodIn), .fullStopEnter(fullStopEnter),
    .wrFlagEn(wrFlagEn), .wrEnEn(wrEnEn), .wrData(wrData), .postDiv(postDiv),
    .flagsOut(flagsOut), .enablesOut(enablesOut), .irqOut(irqOut),
    .pllDivRatio(pllDivRatio)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic por();
    @(negedge clk);
    {lowVoltEvt, illegalAddrEvt, timerTick, pllLockIn, oscGoodIn} = '0;
    {fullStopEnter, wrFlagEn, wrEnEn} = '0;
    porRstN = 1'b0;
    tick();
    porRstN = 1'b1;
    tick();
  endtask

  task automatic wrFlags(logic [7:0] d);
    wrFlagEn = 1'b1; wrData = d; tick(); wrFlagEn = 1'b0;
  endtask

  task automatic wrEnables(logic [2:0] d);
    wrEnEn = 1'b1; wrData = {5'b0, d}; tick(); wrEnEn = 1'b0;
  endtask

  task automatic t_reset();
    wrEnables(3'b111);
    timerTick = 1; tick(); timerTick = 0;
    tick();
    porRstN = 1'b0; #1;
    chk("R1 flags during reset", flagsOut, 8'h40);
    chk("R1 enables", enablesOut, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 div", pllDivRatio, 4);
    tick(); porRstN = 1'b1; tick();
  endtask

  task automatic t_w1c();
    por();
    wrFlags(8'h00);
    chk("R3 write zero keeps power-on flag", flagsOut, 8'h40);
    wrFlags(8'h40);
    chk("R3 write one clears power-on flag", flagsOut, 8'h00);
  endtask

  task automatic t_causes();
    por(); wrFlags(8'h40);
    lowVoltEvt = 1; tick(); lowVoltEvt = 0;
    chk("R4 low-voltage sets bit5", flagsOut, 8'h20);
    illegalAddrEvt = 1; tick(); illegalAddrEvt = 0;
    tick();
    chk("R4 illegal-address sets bit2, sticky", flagsOut, 8'h24);
    wrFlags(8'h04);
    chk("R3 selective clear", flagsOut, 8'h20);
    wrFlags(8'hFF);
    chk("R3 clear all", flagsOut, 8'h00);
  endtask

  task automatic t_timer();
    por(); wrFlags(8'h40);
    timerTick = 1; tick(); timerTick = 0;
    chk("R2 timeout flag", flagsOut, 8'h80);
    tick();
    chk("R9 irq masked when disabled", irqOut, 0);
    wrEnables(3'b100);
    chk("R9 enables readback", enablesOut, 3'b100);
    chk("R9 irq not yet", irqOut, 0);
    tick();
    chk("R9 irq one edge after enable", irqOut, 1);
    wrFlags(8'h80);
    chk("R9 irq held one edge after clear", irqOut, 1);
    tick();
    chk("R9 irq drops", irqOut, 0);
  endtask

  task automatic t_lock();
    por(); wrFlags(8'h40); wrEnables(3'b010);
    chk("R10 unlocked div", pllDivRatio, 4);
    pllLockIn = 1; tick();
    chk("R5 lock rise", flagsOut, 8'h18);
    chk("R10 locked div", pllDivRatio, 10);
    chk("R9 lock irq not yet", irqOut, 0);
    tick();
    chk("R9 lock irq", irqOut, 1);
    wrFlags(8'h10);
    chk("R5 lock-change cleared, status kept", flagsOut, 8'h08);
    wrFlags(8'h08);
    chk("R7 write one to lock status", flagsOut, 8'h08);
    pllLockIn = 0; tick();
    chk("R5 lock fall sets change", flagsOut, 8'h10);
    chk("R10 back to safe div", pllDivRatio, 4);
    wrFlags(8'h10);
  endtask

  task automatic t_osc();
    por(); wrFlags(8'h40);
    oscGoodIn = 1; tick();
    chk("R6 osc rise", flagsOut, 8'h03);
    wrFlags(8'h03);
    chk("R7 osc status survives write", flagsOut, 8'h01);
    fullStopEnter = 1; tick();
    chk("R6 full stop clears osc status", flagsOut, 8'h02);
    tick();
    chk("R6 held low in full stop", flagsOut, 8'h02);
    fullStopEnter = 0; wrFlags(8'h02);
    chk("R6 osc back after full stop", flagsOut, 8'h03);
  endtask

  task automatic t_collide();
    por(); wrFlags(8'h40);
    timerTick = 1; wrFlagEn = 1; wrData = 8'h80; tick();
    timerTick = 0; wrFlagEn = 0;
    chk("R8 set wins on bit7", flagsOut, 8'h80);
    illegalAddrEvt = 1; wrFlagEn = 1; wrData = 8'h84; tick();
    illegalAddrEvt = 0; wrFlagEn = 0;
    chk("R8 set wins on bit2, bit7 cleared", flagsOut, 8'h04);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    #1;
    chk("R1 reset flags", flagsOut, 8'h40);
    chk("R1 reset irq", irqOut, 0);
    tick(); porRstN = 1'b1; tick();
    chk("R1 flags after release", flagsOut, 8'h40);
    t_reset();
    t_w1c();
    t_causes();
    t_timer();
    t_lock();
    t_osc();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule